// File: doc/BRIEF.md
# I2C Byte Engine with Clock-Stretch Wait Control

This block moves one byte at a time over an I2C-style two-wire bus, acting either as the clock master or as a clocked slave. Data leaves most significant bit first over eight clocks. A ninth clock carries the acknowledge, which the receiving side drives. Both lines are open-drain. The block only asserts pull-low enables and reads back the wired line levels.

Between bytes the engine pauses by holding SCL low, which is the standard clock-stretch wait. Software chooses where the pause falls: after the eighth falling edge, before the acknowledge, or after the ninth falling edge, once the acknowledge is complete. Software ends the pause in one of two ways. Writing a byte releases SCL and supplies the next byte to shift out. A single-cycle release pulse releases SCL without supplying a byte; a receiving side can write 0xFF instead, so that it drives no data bits. The next clock edge happens only when every device on the bus has let go of SCL.

When the engine is master, a simple fixed-rate generator makes the clock. It starts each high phase only after it reads SCL back high, so a partner can stretch any bit. Start and stop conditions, arbitration and address matching are outside this block.

Top module: `i2c_wait_engine`

## Requirements
- R1: After reset a master-configured engine holds SCL low with `hold`=1, a slave-configured engine releases SCL with `hold`=0, neither pulls SDA, and `wait_irq` is 0.
- R2: The transmitting side places byte bit 7 on SDA for the first clock and bit 0 for the eighth, pulling SDA low for a 0 bit. After the eighth rising SCL edge, `rx_data` of the receiving side holds the byte with the first received bit in bit 7.
- R3: With `cfg_wait9`=0, the engine pulls SCL low and sets `hold`=1 after the eighth falling SCL edge of a byte, before the acknowledge clock.
- R4: With `cfg_wait9`=1, the engine pulls SCL low and sets `hold`=1 after the ninth falling SCL edge, once the acknowledge clock is complete.
- R5: A `dat_we` pulse while `hold`=1 clears `hold` on the next clock edge. The written byte is the next one shifted out: it loads at once when the wait lies at a byte boundary, and it loads at the end of the acknowledge clock when the wait lies before it.
- R6: A `wrel` pulse while `hold`=1 clears `hold` on the next clock edge and leaves the byte unchanged. A receiver that writes 0xFF is released and drives no data bits.
- R7: During the ninth clock the receiver (`cfg_tx`=0) pulls SDA low when `cfg_ack_en`=1 and leaves it released when `cfg_ack_en`=0. After the ninth rising edge, `ack_in` is 1 when SDA read low and 0 when it read high.
- R8: A master drives each SCL low phase for HALF_DIV cycles and then releases SCL. It starts the high phase only after it reads SCL high. While a partner holds SCL low, the master makes no further SCL edge.
- R9: A `wrel` pulse while `hold`=0 has no effect: SCL keeps running and the byte in flight completes unchanged.
- R10: `wait_irq` is a pulse of exactly one cycle, raised together with `hold` each time a wait is entered, and never raised by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = generate SCL; 0 = follow SCL from the bus |
| cfg_tx | input | 1 | 1 = this side sends data bytes; 0 = this side receives and acknowledges |
| cfg_ack_en | input | 1 | Receiver pulls SDA low during the ninth clock |
| cfg_wait9 | input | 1 | Wait point: 0 = after the eighth clock, 1 = after the ninth |
| dat_we | input | 1 | Byte write strobe; also ends a wait |
| dat_wdata | input | 8 | Byte to shift out |
| wrel | input | 1 | Single-cycle wait release pulse |
| scl_i | input | 1 | Wired SCL line level |
| sda_i | input | 1 | Wired SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| rx_data | output | 8 | Last byte received |
| ack_in | output | 1 | Acknowledge observed on the last ninth clock |
| hold | output | 1 | Engine is in a wait and is holding SCL low |
| wait_irq | output | 1 | One-cycle pulse on entry to a wait |

## Verification
Two engines share a wired-AND bus. The bytes sent are 0xA5, 0x00, 0xFF and 0x3C. Alternating bits, an all-low byte and an all-released byte separate a correct bit order and SDA drive from a reversed, stuck or inverted path. The first pairing has the master waiting after the ninth clock and the slave after the eighth. The second reverses the wait points and turns off the acknowledge. Running both shows whether each wait point is taken at the right edge and whether the acknowledge result depends on the enable. Each slave wait is held for many cycles and the bench checks that no SCL edge appears meanwhile, which shows that the master stalls. The slave is released by a release pulse on some bytes and by a 0xFF write on others, and a release pulse is also sent outside any wait.

// File: rtl/i2cw_pkg.sv
// Package i2cw_pkg
// Shared constants and types for the I2C byte engine with clock-stretch waits.
// Assumes one data byte of eight bits followed by a single acknowledge slot.
package i2cw_pkg;

    localparam int          BYTE_W        = 8;
    localparam int          CNT_W         = 4;
    // bit slot index: 0..7 are data bits (MSB first), 8 is the acknowledge slot
    localparam logic [3:0]  LAST_DATA_IDX = 4'd7;
    localparam logic [3:0]  ACK_IDX       = 4'd8;

    // phases of the master clock generator
    typedef enum logic [1:0] {
        GEN_LOW  = 2'd0,   // pulling SCL low for the low phase
        GEN_REL  = 2'd1,   // released, waiting for the line to read high
        GEN_HIGH = 2'd2    // line high, timing the high phase
    } gen_state_e;

endpackage

// File: rtl/i2cw_line_sense.sv
// Module i2cw_line_sense
// Detects rising and falling transitions of the wired SCL line.
// Assumes scl_i is already synchronous to clk (bus synchronisers live outside
// this block) and that SCL is low when reset is released, as it is whenever a
// master engine is on the bus, so that no edge is reported at reset exit.
module i2cw_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_prev_q;

    // remember the line level of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b0;
        end else begin
            scl_prev_q <= scl_i;
        end
    end

    // compare the current level with the previous one
    always_comb begin
        scl_rise = scl_i & ~scl_prev_q;
        scl_fall = ~scl_i & scl_prev_q;
    end

endmodule

// File: rtl/i2cw_clkgen.sv
// Module i2cw_clkgen
// Fixed-rate master SCL generator that honours clock stretching.
// The low phase is timed from the moment the generator pulls SCL low. The high
// phase starts only once the released line reads high, so a partner holding
// SCL low stalls the generator. While enable is low the generator is parked
// at the start of a low phase. Assumes HALF_DIV >= 2, so partners see each
// falling edge before the low phase ends.
module i2cw_clkgen
    import i2cw_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_i,
    output logic pull_low
);

    localparam int PW = $clog2(HALF_DIV + 1);
    localparam logic [PW-1:0] PHASE_LAST = PW'(HALF_DIV - 1);

    gen_state_e    state_q;
    logic [PW-1:0] phase_q;

    // step through low, release and high phases
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q <= GEN_LOW;
            phase_q <= '0;
        end else begin
            case (state_q)
                GEN_LOW: begin
                    if (phase_q == PHASE_LAST) begin
                        state_q <= GEN_REL;
                        phase_q <= '0;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
                GEN_REL: begin
                    if (scl_i) begin
                        state_q <= GEN_HIGH;
                        phase_q <= '0;
                    end
                end
                GEN_HIGH: begin
                    if (phase_q == PHASE_LAST) begin
                        state_q <= GEN_LOW;
                        phase_q <= '0;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= GEN_LOW;
                    phase_q <= '0;
                end
            endcase
        end
    end

    // drive the line only in the low phase
    always_comb begin
        pull_low = enable && (state_q == GEN_LOW);
    end

endmodule

// File: rtl/i2cw_byte_ctrl.sv
// Module i2cw_byte_ctrl
// Bit-slot counter, transmit shifter, receive capture and wait control.
// It counts falling SCL edges per byte (slots 0..7 data, slot 8 acknowledge)
// and enters a wait after the eighth or the ninth falling edge, as chosen by
// cfg_wait9. A byte write or a release pulse ends the wait. A byte written
// during a wait at a byte boundary loads the shifter at once; otherwise it
// waits in the holding register until the acknowledge slot ends.
// Assumes configuration inputs change only while reset is asserted.
module i2cw_byte_ctrl
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_tx,
    input  logic              cfg_ack_en,
    input  logic              cfg_wait9,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_i,
    input  logic              dat_we,
    input  logic [BYTE_W-1:0] dat_wdata,
    input  logic              wrel,
    output logic              hold,
    output logic              wait_irq,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] rx_data,
    output logic              ack_in
);

    logic [CNT_W-1:0]  slot_q;
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] txbuf_q;
    logic [BYTE_W-1:0] rxsh_q;
    logic [BYTE_W-1:0] rx_data_q;
    logic              hold_q;
    logic              irq_q;
    logic              ack_q;
    logic              release_req;
    logic              wait_at_eight;
    logic              wait_at_nine;

    // decode the wait release and wait entry conditions
    always_comb begin
        release_req   = hold_q && (dat_we || wrel);
        wait_at_eight = scl_fall && (slot_q == LAST_DATA_IDX) && !cfg_wait9;
        wait_at_nine  = scl_fall && (slot_q == ACK_IDX) && cfg_wait9;
    end

    // advance bit slots, shift transmit data and manage the wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= '0;
            shift_q <= '1;
            txbuf_q <= '1;
            hold_q  <= cfg_master;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= wait_at_eight || wait_at_nine;
            if (dat_we) begin
                txbuf_q <= dat_wdata;
            end
            if (scl_fall) begin
                if (slot_q == ACK_IDX) begin
                    slot_q  <= '0;
                    shift_q <= dat_we ? dat_wdata : txbuf_q;
                end else begin
                    slot_q  <= slot_q + 1'b1;
                    shift_q <= {shift_q[BYTE_W-2:0], 1'b1};
                end
                if (wait_at_eight || wait_at_nine) begin
                    hold_q <= 1'b1;
                end
            end else if (release_req) begin
                hold_q <= 1'b0;
                if (dat_we && (slot_q == '0)) begin
                    shift_q <= dat_wdata;
                end
            end
        end
    end

    // capture received data bits and the acknowledge on rising SCL
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxsh_q    <= '0;
            rx_data_q <= '0;
            ack_q     <= 1'b0;
        end else if (scl_rise) begin
            if (slot_q < ACK_IDX) begin
                rxsh_q <= {rxsh_q[BYTE_W-2:0], sda_i};
                if (slot_q == LAST_DATA_IDX) begin
                    rx_data_q <= {rxsh_q[BYTE_W-2:0], sda_i};
                end
            end else begin
                ack_q <= ~sda_i;
            end
        end
    end

    // SDA drive: data bit while in data slots, acknowledge from the receiver
    always_comb begin
        if (slot_q < ACK_IDX) begin
            sda_pull = ~shift_q[BYTE_W-1];
        end else begin
            sda_pull = ~cfg_tx & cfg_ack_en;
        end
    end

    assign hold     = hold_q;
    assign wait_irq = irq_q;
    assign rx_data  = rx_data_q;
    assign ack_in   = ack_q;

endmodule

// File: rtl/i2c_wait_engine.sv
// Module i2c_wait_engine
// Top of the I2C byte engine with selectable clock-stretch wait point.
// Combines SCL edge sensing, the byte controller and, in master mode, the
// fixed-rate clock generator. SCL is pulled low by the wait hold or by the
// generator's low phase. Both lines are open-drain pull-low enables; the
// wired levels come back on scl_i and sda_i.
module i2c_wait_engine
    import i2cw_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_tx,
    input  logic              cfg_ack_en,
    input  logic              cfg_wait9,
    input  logic              dat_we,
    input  logic [BYTE_W-1:0] dat_wdata,
    input  logic              wrel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              ack_in,
    output logic              hold,
    output logic              wait_irq
);

    logic scl_rise;
    logic scl_fall;
    logic gen_pull;
    logic gen_enable;
    logic sda_pull;

    i2cw_line_sense u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2cw_byte_ctrl u_byte (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_master (cfg_master),
        .cfg_tx     (cfg_tx),
        .cfg_ack_en (cfg_ack_en),
        .cfg_wait9  (cfg_wait9),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_i      (sda_i),
        .dat_we     (dat_we),
        .dat_wdata  (dat_wdata),
        .wrel       (wrel),
        .hold       (hold),
        .wait_irq   (wait_irq),
        .sda_pull   (sda_pull),
        .rx_data    (rx_data),
        .ack_in     (ack_in)
    );

    // the generator runs only for a master that is not in a wait
    assign gen_enable = cfg_master & ~hold;

    i2cw_clkgen #(
        .HALF_DIV (HALF_DIV)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (gen_enable),
        .scl_i    (scl_i),
        .pull_low (gen_pull)
    );

    // combine the wait hold with the generator low phase
    always_comb begin
        scl_oe = hold | gen_pull;
        sda_oe = sda_pull;
    end

endmodule

// File: rtl/i2cw_checker.sv
// Module i2cw_checker
// Protocol checks for i2c_wait_engine, attached with bind below.
// Assumes configuration inputs stay constant outside reset.
module i2cw_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_master,
    input logic dat_we,
    input logic wrel,
    input logic scl_i,
    input logic scl_oe,
    input logic sda_oe,
    input logic hold,
    input logic wait_irq
);

    // R10: the wait interrupt lasts one cycle
    a_r10_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wait_irq |=> !wait_irq);

    // R10: the wait interrupt appears only together with the hold
    a_r10_irq_only_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        wait_irq |-> hold);

    // R5 and R6: a write or release pulse during a wait ends it next cycle
    a_r5_release_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && (dat_we || wrel)) |=> !hold);

    // R8: a master starts pulling SCL low only after the line read high
    a_r8_pull_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $rose(scl_oe)) |-> $past(scl_i));

    // R2: the SDA drive changes only while SCL is low
    a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

endmodule

bind i2c_wait_engine i2cw_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_master (cfg_master),
    .dat_we     (dat_we),
    .wrel       (wrel),
    .scl_i      (scl_i),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .hold       (hold),
    .wait_irq   (wait_irq)
);

// File: tb/i2c_wait_engine_test.sv
// Bench for i2c_wait_engine: a master engine (uut) and a slave engine (peer)
// share a wired-AND bus. A driver task queues each byte it sends; a monitor
// pops the queue whenever the peer enters a wait and compares the received byte.
module i2c_wait_engine_test;

    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       m_master, m_tx, m_ack, m_w9, m_we, m_wrel;
    logic [7:0] m_wd;
    logic       p_master, p_tx, p_ack, p_w9, p_we, p_wrel;
    logic [7:0] p_wd;
    logic       m_scl_oe, m_sda_oe, m_ackin, m_hold, m_irq;
    logic       p_scl_oe, p_sda_oe, p_ackin, p_hold, p_irq;
    logic [7:0] m_rx, p_rx;
    logic       scl_line, sda_line;

    assign scl_line = ~(m_scl_oe | p_scl_oe);
    assign sda_line = ~(m_sda_oe | p_sda_oe);

    i2c_wait_engine #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_master(m_master), .cfg_tx(m_tx),
        .cfg_ack_en(m_ack), .cfg_wait9(m_w9), .dat_we(m_we), .dat_wdata(m_wd),
        .wrel(m_wrel), .scl_i(scl_line), .sda_i(sda_line), .scl_oe(m_scl_oe),
        .sda_oe(m_sda_oe), .rx_data(m_rx), .ack_in(m_ackin), .hold(m_hold),
        .wait_irq(m_irq));

    i2c_wait_engine #(.HALF_DIV(HALF)) peer (
        .clk(clk), .rst_n(rst_n), .cfg_master(p_master), .cfg_tx(p_tx),
        .cfg_ack_en(p_ack), .cfg_wait9(p_w9), .dat_we(p_we), .dat_wdata(p_wd),
        .wrel(p_wrel), .scl_i(scl_line), .sda_i(sda_line), .scl_oe(p_scl_oe),
        .sda_oe(p_sda_oe), .rx_data(p_rx), .ack_in(p_ackin), .hold(p_hold),
        .wait_irq(p_irq));

    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;
    logic [7:0] exp_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic m_write(input logic [7:0] b);
        @(negedge clk); m_we = 1'b1; m_wd = b;
        @(negedge clk); m_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        exp_q.push_back(b);
        m_write(b);
    endtask

    task automatic m_release();
        @(negedge clk); m_wrel = 1'b1;
        @(negedge clk); m_wrel = 1'b0;
    endtask

    task automatic p_release(input bit by_write);
        @(negedge clk);
        if (by_write) begin p_we = 1'b1; p_wd = 8'hFF; end
        else p_wrel = 1'b1;
        @(negedge clk); p_we = 1'b0; p_wrel = 1'b0;
    endtask

    // SCL must stay low for the given cycles while the peer stretches it
    task automatic stretch_check(input int cycles, input string tag);
        int highs = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (scl_line) highs++;
        end
        check(highs == 0, tag, highs, 0);
    endtask

    // monitor: compare each received byte when the peer enters its wait
    always @(negedge clk) begin
        if (rst_n && p_irq) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected byte", p_rx, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(p_rx == e, "R2 received byte", p_rx, e);
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R8 watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] vals [4];
        vals = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
        m_we = 0; m_wrel = 0; m_wd = 0; p_we = 0; p_wrel = 0; p_wd = 0;

        // phase 1: master waits after clock 9, slave receiver waits after clock 8
        m_master = 1; m_tx = 1; m_ack = 0; m_w9 = 1;
        p_master = 0; p_tx = 0; p_ack = 1; p_w9 = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(m_hold == 1'b1 && scl_line == 1'b0, "R1 master holds SCL", m_hold, 1);
        check(p_hold == 1'b0 && p_scl_oe == 1'b0, "R1 slave releases SCL", p_scl_oe, 0);
        check(sda_line == 1'b1, "R1 SDA released", sda_line, 1);
        check(m_irq == 1'b0 && p_irq == 1'b0, "R10 no irq at reset", m_irq, 0);

        for (int i = 0; i < 4; i++) begin
            send(vals[i]);
            if (i == 3) begin
                repeat (3) @(negedge clk);
                m_release();
                check(m_hold == 1'b0, "R9 release outside wait ignored", m_hold, 0);
            end
            while (!p_irq) @(negedge clk);
            check(p_hold == 1'b1 && scl_line == 1'b0, "R3 slave waits after clock 8", p_hold, 1);
            check(m_hold == 1'b0, "R3 master not waiting at clock 8", m_hold, 0);
            @(negedge clk);
            check(p_irq == 1'b0, "R10 irq one cycle", p_irq, 0);
            stretch_check(30, "R8 master stalls while SCL held");
            p_release(i % 2 == 1);
            while (!m_irq) @(negedge clk);
            check(m_hold == 1'b1 && scl_line == 1'b0, "R4 master waits after clock 9", m_hold, 1);
            check(m_ackin == 1'b1, "R7 acknowledge seen", m_ackin, 1);
        end
        @(negedge clk);
        check(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);

        // phase 2: master waits after clock 8, slave after clock 9, no acknowledge
        rst_n = 1'b0;
        m_w9 = 0; p_w9 = 1; p_ack = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(p_hold == 1'b0 && m_hold == 1'b1, "R1 hold after reset", p_hold, 0);

        send(8'h5A);
        while (!m_irq) @(negedge clk);
        check(m_hold == 1'b1 && p_hold == 1'b0, "R3 master waits after clock 8", m_hold, 1);
        stretch_check(20, "R3 SCL held in wait");
        send(8'hC3);
        check(m_hold == 1'b0, "R5 write ends wait", m_hold, 0);
        while (!p_irq) @(negedge clk);
        check(p_hold == 1'b1 && scl_line == 1'b0, "R4 slave waits after clock 9", p_hold, 1);
        check(m_ackin == 1'b0, "R7 no acknowledge when disabled", m_ackin, 0);
        stretch_check(20, "R8 master stalls behind slave");
        p_release(1'b0);
        check(p_hold == 1'b0, "R6 release pulse ends wait", p_hold, 0);
        while (!m_irq) @(negedge clk);
        m_release();
        check(m_hold == 1'b0, "R6 master released by pulse", m_hold, 0);
        while (!p_irq) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R5 next byte delivered", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule